// File: doc/BRIEF.md
# Smart-Card Character Receiver

This block receives characters from the asynchronous I/O line of a smart-card interface. A bit time (one ETU) lasts a programmable whole number of reference-clock cycles, between 1 and 2047. The reference clock comes from an upstream baud generator and also clocks this block. Each character has a low start bit, eight data bits sent least significant bit first, an even parity bit and a high stop bit. Once a character is complete, its data byte goes to a holding register and a ready flag is raised. Sticky flags report parity mismatches and characters that were lost to overrun.

Software controls the receiver with single-cycle pulses: enable, disable and receiver reset. It also writes a divider register. The divider may be written at any time, but the receiver only uses the new value when it is next enabled. A disable pulse that arrives during a character takes effect only after that character has been stored. A receiver reset abandons reception at once and clears the holding register and the flags. It leaves the divider and the enable state unchanged.

Top module: `sc_rx`

## Requirements
- R1: After the active-low reset, `rx_on`, `rx_ready`, `par_err`, `ovr_err` and `rx_data` are all zero, and the divider register holds 372.
- R2: When enabled with divider D, the block samples each bit near the middle of its D-cycle ETU, timed from the falling edge of the start bit. The first data bit received is bit 0 of `rx_data`. The block stores the byte when it samples the stop bit.
- R3: While `rx_on` is low, line activity is ignored: no character is captured and `rx_ready` does not rise.
- R4: A write to the divider register changes the bit time only at the next enable pulse that arrives while `rx_on` is low. Characters keep using the previous value until then.
- R5: A start bit that is no longer low at its mid-ETU sample is rejected, and the receiver returns to waiting for a falling edge.
- R6: Storing a character sets `rx_ready`. A `rd_ack` pulse clears it, unless a new character is stored in the same cycle.
- R7: If the parity bit does not make the total count of ones over data and parity even, `par_err` is set. It stays set until a reset or a receiver reset.
- R8: If a character is stored while `rx_ready` is still set and no `rd_ack` arrives in that cycle, `ovr_err` is set and stays set. The new byte replaces the old one.
- R9: A disable pulse during a character keeps `rx_on` high until that character is stored. `rx_on` falls after the store, and later characters are ignored.
- R10: A receiver reset pulse aborts any character in progress, so that character is never stored. It clears `rx_ready`, `rx_data`, `par_err` and `ovr_err`, and keeps the divider and `rx_on`.
- R11: A disable pulse while no character is in progress clears `rx_on` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Smart-card reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial I/O line; idle is high |
| rx_en | input | 1 | Enable pulse |
| rx_dis | input | 1 | Disable pulse; wins over `rx_en` in the same cycle |
| rx_srst | input | 1 | Receiver reset pulse |
| div_we | input | 1 | Divider register write strobe |
| div_wdata | input | DIV_W | Divider value, in cycles per ETU |
| rd_ack | input | 1 | Read acknowledge; clears `rx_ready` |
| rx_on | output | 1 | Receiver enabled |
| rx_busy | output | 1 | A character is in progress |
| rx_data | output | DATA_W | Holding register |
| rx_ready | output | 1 | Holding register has unread data |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun |

## Verification
The bench builds the block with its default parameters: an 11-bit divider that resets to 372, 8 data bits and a 2-stage input synchronizer. That leaves the reset rate of 372 cycles per ETU reachable at full length. At run time the bench also programs dividers from 8 to 48, so that many characters, rate changes and enable, disable and reset events fit within a short run. Random bytes, divider values and parity faults are mixed with directed cases: a start glitch, overrun, an abort mid-character and a disable mid-character.

// File: rtl/sc_rx_pkg.sv
// Package: shared types for the smart-card receiver.
// Assumes nothing beyond IEEE 1800-2017.
package sc_rx_pkg;
    // Frame position of the receive state machine
    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } fr_state_t;
endpackage

// File: rtl/sc_rx_sync.sv
// Module: multi-stage synchronizer for the asynchronous I/O line.
// Assumes STAGES >= 1; every stage resets to RST_VAL (the line's idle level).
module sc_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first stage captures the raw line
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= RST_VAL;
                else        pipe[0] <= d_i;
            end
        end else begin : g_next
            // later stages pass the value along
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= RST_VAL;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/sc_rx_cfg.sv
// Module: divider register, working divider copy and enable/disable control.
// Assumes single-cycle control pulses. Disable wins over enable. A disable that
// arrives during a character is held pending until the frame engine goes idle.
module sc_rx_cfg #(
    parameter int DIV_W   = 11,
    parameter int DIV_RST = 372
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             dis_i,
    input  logic             srst_i,
    input  logic             div_we_i,
    input  logic [DIV_W-1:0] div_wdata_i,
    input  logic             busy_i,
    output logic             on_o,
    output logic             accept_o,
    output logic [DIV_W-1:0] work_div_o
);
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] work_q;
    logic             on_q;
    logic             pend_q;

    // software-visible divider register; only a hard reset restores it
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= DIV_INIT;
        else if (div_we_i) div_q <= div_wdata_i;
    end

    // working copy, taken when the receiver goes from off to on
    always_ff @(posedge clk) begin
        if (!rst_n)                        work_q <= DIV_INIT;
        else if (en_i && !dis_i && !on_q)  work_q <= div_q;
    end

    // enable state with a graceful (pending) disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            pend_q <= 1'b0;
        end else if (srst_i) begin
            if (pend_q || dis_i) on_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (dis_i) begin
            if (busy_i) pend_q <= 1'b1;
            else begin
                on_q   <= 1'b0;
                pend_q <= 1'b0;
            end
        end else if (en_i) begin
            on_q   <= 1'b1;
            pend_q <= 1'b0;
        end else if (pend_q && !busy_i) begin
            on_q   <= 1'b0;
            pend_q <= 1'b0;
        end
    end

    assign on_o       = on_q;
    assign work_div_o = work_q;
    assign accept_o   = on_q && !pend_q && !dis_i && !srst_i;

    // R11
    idle_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_i && !busy_i) |=> !on_q);
    // R9
    busy_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q && busy_i && dis_i && !srst_i) |=> on_q);
    // R4
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_q |=> $stable(work_q));
endmodule

// File: rtl/sc_rx_frame.sv
// Module: frame engine. Detects the start edge, times ETUs and shifts in data.
// Assumes a synchronized line input and a divider that stays constant while busy.
// Emits a one-cycle done pulse with the byte and a parity verdict.
module sc_rx_frame
    import sc_rx_pkg::*;
#(
    parameter int DIV_W  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_i,
    input  logic              accept_i,
    input  logic              line_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bad_o
);
    localparam int               IDX_W    = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
    localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

    fr_state_t         state;
    logic [DIV_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic              prev_q;
    logic              done_q;
    logic              bad_q;
    logic              tick;

    assign tick = (cnt == '0);

    // previous line level, used to detect the falling start edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= line_i;
    end

    // frame state machine, ETU counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n || srst_i) begin
            state   <= FR_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            done_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state == FR_IDLE) begin
                if (accept_i && prev_q && !line_i) begin
                    state <= FR_START;
                    cnt   <= div_i >> 1;
                end
            end else if (!tick) begin
                cnt <= cnt - ONE;
            end else begin
                cnt <= div_i - ONE;
                unique case (state)
                    FR_START: begin
                        bit_idx <= '0;
                        state   <= line_i ? FR_IDLE : FR_DATA;
                    end
                    FR_DATA: begin
                        shreg   <= {line_i, shreg[DATA_W-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == LAST_IDX) state <= FR_PAR;
                    end
                    FR_PAR: begin
                        par_q <= line_i;
                        state <= FR_STOP;
                    end
                    FR_STOP: begin
                        done_q <= 1'b1;
                        bad_q  <= (^shreg) ^ par_q;
                        state  <= FR_IDLE;
                    end
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end

    assign busy_o    = (state != FR_IDLE);
    assign done_o    = done_q;
    assign data_o    = shreg;
    assign par_bad_o = bad_q;

    // R5
    glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_START && tick && line_i) |=> (state == FR_IDLE && !done_o));
    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (state == FR_IDLE && !done_o));
    // R2
    etu_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FR_IDLE) |-> (cnt <= div_i));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/sc_rx.sv
// Module: smart-card character receiver top level.
// Assumes clk is the smart-card reference clock and rst_n is synchronous.
// Holds the received byte, the ready flag and the sticky error flags.
module sc_rx #(
    parameter int DIV_W       = 11,
    parameter int DIV_RST     = 372,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              rx_en,
    input  logic              rx_dis,
    input  logic              rx_srst,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              rd_ack,
    output logic              rx_on,
    output logic              rx_busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              ovr_err
);
    logic              line_s;
    logic              accept;
    logic [DIV_W-1:0]  work_div;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_bad;
    logic [DATA_W-1:0] hold_q;
    logic              ready_q;
    logic              perr_q;
    logic              ovr_q;

    sc_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (rx_line),
        .q_o  (line_s)
    );

    sc_rx_cfg #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (rx_en),
        .dis_i      (rx_dis),
        .srst_i     (rx_srst),
        .div_we_i   (div_we),
        .div_wdata_i(div_wdata),
        .busy_i     (busy),
        .on_o       (rx_on),
        .accept_o   (accept),
        .work_div_o (work_div)
    );

    sc_rx_frame #(.DIV_W(DIV_W), .DATA_W(DATA_W)) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_i   (rx_srst),
        .accept_i (accept),
        .line_i   (line_s),
        .div_i    (work_div),
        .busy_o   (busy),
        .done_o   (done),
        .data_o   (fr_data),
        .par_bad_o(fr_bad)
    );

    // holding register, ready flag and sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n || rx_srst) begin
            hold_q  <= '0;
            ready_q <= 1'b0;
            perr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (done) begin
            hold_q  <= fr_data;
            ready_q <= 1'b1;
            if (fr_bad)             perr_q <= 1'b1;
            if (ready_q && !rd_ack) ovr_q  <= 1'b1;
        end else if (rd_ack) begin
            ready_q <= 1'b0;
        end
    end

    assign rx_busy  = busy;
    assign rx_data  = hold_q;
    assign rx_ready = ready_q;
    assign par_err  = perr_q;
    assign ovr_err  = ovr_q;

    // R6
    ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(done));
    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_srst |=> (!ready_q && !perr_q && !ovr_q));
    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ready_q && !rd_ack && !rx_srst) |=> ovr_q);
    // R7
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_q && !rx_srst) |=> perr_q);
    // R3
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |-> !busy);
endmodule

// File: tb/test_sc_rx.sv
// Bench: self-checking stimulus for sc_rx with a seeded random phase.
module test_sc_rx;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_line, rx_en, rx_dis, rx_srst, div_we, rd_ack;
    logic [10:0] div_wdata;
    logic       rx_on, rx_busy, rx_ready, par_err, ovr_err;
    logic [7:0] rx_data;
    int         n_chk = 0;
    int         n_err = 0;

    always #5 clk = ~clk;

    sc_rx i_sc_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_en(rx_en),
        .rx_dis(rx_dis), .rx_srst(rx_srst), .div_we(div_we),
        .div_wdata(div_wdata), .rd_ack(rd_ack), .rx_on(rx_on),
        .rx_busy(rx_busy), .rx_data(rx_data), .rx_ready(rx_ready),
        .par_err(par_err), .ovr_err(ovr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_en();   rx_en = 1'b1;   @(negedge clk); rx_en = 1'b0;   endtask
    task automatic do_dis();  rx_dis = 1'b1;  @(negedge clk); rx_dis = 1'b0;  endtask
    task automatic do_srst(); rx_srst = 1'b1; @(negedge clk); rx_srst = 1'b0; endtask
    task automatic do_ack();  rd_ack = 1'b1;  @(negedge clk); rd_ack = 1'b0;  endtask

    task automatic write_div(input int v);
        div_we = 1'b1; div_wdata = 11'(v);
        @(negedge clk);
        div_we = 1'b0;
    endtask

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    // evt_kind: 0 none, 1 disable pulse at bit evt_bit, 2 receiver reset and abort there
    task automatic send_frame(input logic [7:0] d, input int div, input bit bad,
                              input int evt_bit, input int evt_kind);
        logic [10:0] fr;
        fr = {1'b1, even_par(d) ^ bad, d, 1'b0};
        for (int b = 0; b < 11; b++) begin
            rx_line = fr[b];
            if (b == evt_bit && evt_kind == 1) begin
                do_dis();
                @(negedge clk);
                chk("R9 on kept mid-char", 32'(rx_on), 32'd1);
                cyc(div - 2);
            end else if (b == evt_bit && evt_kind == 2) begin
                do_srst();
                rx_line = 1'b1;
                cyc(div * (11 - b));
                return;
            end else begin
                cyc(div);
            end
        end
        rx_line = 1'b1;
        cyc(2 * div);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int         div;
        bit         bad;
        logic       exp_perr;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rx_line = 1'b1; rx_en = 1'b0; rx_dis = 1'b0;
        rx_srst = 1'b0; div_we = 1'b0; div_wdata = '0; rd_ack = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 rx_on", 32'(rx_on), 0);
        chk("R1 rx_ready", 32'(rx_ready), 0);
        chk("R1 par_err", 32'(par_err), 0);
        chk("R1 ovr_err", 32'(ovr_err), 0);
        chk("R1 rx_data", 32'(rx_data), 0);
        // R3 disabled receiver ignores a character
        send_frame(8'h96, 372, 0, -1, 0);
        chk("R3 no capture while off", 32'(rx_ready), 0);
        // R1 default divider 372, R2 frame
        do_en();
        send_frame(8'hA5, 372, 0, -1, 0);
        chk("R1 default div ready", 32'(rx_ready), 1);
        chk("R2 data 372", 32'(rx_data), 32'hA5);
        do_ack();
        chk("R6 ack clears ready", 32'(rx_ready), 0);
        // R11 idle disable is immediate
        do_dis();
        chk("R11 rx_on off", 32'(rx_on), 0);
        // R4 new divider at enable
        write_div(16);
        do_en();
        send_frame(8'h3C, 16, 0, -1, 0);
        chk("R4 data div16", 32'(rx_data), 32'h3C);
        do_ack();
        write_div(24);
        send_frame(8'h5A, 16, 0, -1, 0);
        chk("R4 old div kept", 32'(rx_data), 32'h5A);
        do_ack();
        do_dis();
        do_en();
        send_frame(8'hC3, 24, 0, -1, 0);
        chk("R4 new div after enable", 32'(rx_data), 32'hC3);
        do_ack();
        // R5 start glitch rejected
        rx_line = 1'b0; cyc(2); rx_line = 1'b1;
        cyc(3 * 24);
        chk("R5 glitch ignored", 32'(rx_ready), 0);
        send_frame(8'h81, 24, 0, -1, 0);
        chk("R5 next char ok", 32'(rx_data), 32'h81);
        do_ack();
        // R7 parity error sticky
        send_frame(8'h7E, 24, 1, -1, 0);
        chk("R7 par_err set", 32'(par_err), 1);
        chk("R7 data kept", 32'(rx_data), 32'h7E);
        do_ack();
        send_frame(8'h11, 24, 0, -1, 0);
        chk("R7 par_err sticky", 32'(par_err), 1);
        do_ack();
        // R8 overrun
        send_frame(8'h22, 24, 0, -1, 0);
        chk("R8 no overrun yet", 32'(ovr_err), 0);
        send_frame(8'h44, 24, 0, -1, 0);
        chk("R8 ovr_err set", 32'(ovr_err), 1);
        chk("R8 newest data", 32'(rx_data), 32'h44);
        do_ack();
        chk("R8 ovr_err sticky", 32'(ovr_err), 1);
        // R10 receiver reset
        do_srst();
        chk("R10 par_err cleared", 32'(par_err), 0);
        chk("R10 ovr_err cleared", 32'(ovr_err), 0);
        chk("R10 data cleared", 32'(rx_data), 0);
        chk("R10 enable kept", 32'(rx_on), 1);
        send_frame(8'hF0, 24, 0, 4, 2);
        chk("R10 aborted char not stored", 32'(rx_ready), 0);
        chk("R10 engine idle", 32'(rx_busy), 0);
        send_frame(8'h0F, 24, 0, -1, 0);
        chk("R10 divider kept", 32'(rx_data), 32'h0F);
        do_ack();
        // R9 graceful disable
        send_frame(8'h69, 24, 0, 3, 1);
        chk("R9 char finished", 32'(rx_data), 32'h69);
        chk("R9 ready", 32'(rx_ready), 1);
        chk("R9 off after char", 32'(rx_on), 0);
        do_ack();
        send_frame(8'h55, 24, 0, -1, 0);
        chk("R9 later char ignored", 32'(rx_ready), 0);
        // R2/R7 random characters and rates
        do_srst();
        exp_perr = 1'b0;
        for (int i = 0; i < 16; i++) begin
            div = 8 + int'($urandom % 41);
            d   = 8'($urandom);
            bad = (($urandom % 5) == 0);
            do_dis();
            write_div(div);
            do_en();
            send_frame(d, div, bad, -1, 0);
            exp_perr = exp_perr | bad;
            chk("R2 random data", 32'(rx_data), 32'(d));
            chk("R7 random parity flag", 32'(par_err), 32'(exp_perr));
            do_ack();
        end
        finish_run();
    end
endmodule